// File: doc/BRIEF.md
# H-Bridge Command Decoder with Latched Fault Handling

This block is the digital gate-control stage for one full bridge made of two half-bridge legs. Each leg has its own polarity input: when the bridge is running, a high polarity turns that leg's high-side switch on, and a low polarity turns its low-side switch on. Driving both legs the same way gives a freewheel through the two high sides or through the two low sides. An active-high disable input and an active-high enable input can both switch every leg off. Low enable also puts the bridge into sleep. An undervoltage level and a fault request from the protection circuits also switch the legs off. The block drives an active-low status flag and a sleep indication.

A fault request arrives as a synchronous pulse. It switches off every leg and holds the status flag low until a clear event. A clear event is either a falling edge of disable or a rising edge of enable. Undervoltage does not latch and releases by itself. All inputs pass through a two-flop synchronizer, and the edge detection works on the synchronized values. The command outputs are registered.

Top module: `hb_cmd_top`

## Requirements
- R1: While reset is high and on the first edge after it, every leg is off (hiz_o=1, hs_on_o=0, ls_on_o=0), stat_n_o=1 and sleep_o=1. The synchronizer resets to idle values: polarity 1, disable 1, enable 0, undervoltage 0, fault 0.
- R2: With en_i=1, dis_i=0, uv_i=0 and no latched fault, leg k (bit k of every vector port) has hs_on_o[k]=pol_i[k] and ls_on_o[k]=!pol_i[k]. hiz_o[k]=0 and stat_n_o=1.
- R3: In the running state, pol_i=2'b00 turns both low sides on (low freewheel) and pol_i=2'b11 turns both high sides on (high freewheel).
- R4: In every cycle, each leg has exactly one of hs_on_o, ls_on_o, hiz_o set. The high side and low side of a leg are never on together.
- R5: With en_i=1 and dis_i=1, every leg is off, stat_n_o=0 and sleep_o=0.
- R6: With en_i=0, every leg is off, sleep_o=1 and stat_n_o=1, whatever the other inputs are.
- R7: A one-cycle pulse on flt_i latches a fault. All legs stay off and stat_n_o stays 0 (while enabled), and polarity changes have no effect.
- R8: A latched fault clears only on a 1-to-0 change of synchronized disable or a 0-to-1 change of synchronized enable. A rising disable and an undervoltage episode do not clear it. A fault request that reaches the latch in the same cycle as a clear event leaves the fault latched.
- R9: uv_i=1 switches every leg off and drives stat_n_o=0. When uv_i returns to 0, the outputs resume with no clear event.
- R10: An input change made between edges appears at the outputs on the third rising edge after it (two synchronizer stages plus the output register).
- R11: On the edge where a clear event removes a latched fault, the outputs already show the state that the current inputs select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pol_i | input | LEGS | Per-leg polarity command |
| dis_i | input | 1 | Active-high disable |
| en_i | input | 1 | Active-high enable; low selects sleep |
| uv_i | input | 1 | Undervoltage level from supply monitor |
| flt_i | input | 1 | Latching fault request pulse (short circuit, overtemperature) |
| hs_on_o | output | LEGS | High-side switch on, per leg |
| ls_on_o | output | LEGS | Low-side switch on, per leg |
| hiz_o | output | LEGS | Leg tri-stated (both switches off) |
| stat_n_o | output | 1 | Active-low status flag |
| sleep_o | output | 1 | Sleep indication |

## Verification
A new fault request and a clear event can reach the latch in the same cycle. The bench provokes this by driving the falling edge of disable and the fault pulse at the same clock, so both leave the synchronizer together. The expected result is that the fault stays latched, with the legs off and the flag low. A cycle-accurate behavioural model in the bench checks every output on every clock. Directed checks also confirm the exact release edge of each clear.

// File: rtl/hb_cmd_pkg.sv
package hb_cmd_pkg;

  // per-leg drive command
  typedef struct packed {
    logic hs;
    logic ls;
    logic hiz;
  } leg_drv_t;

  localparam leg_drv_t LEG_OFF = '{hs: 1'b0, ls: 1'b0, hiz: 1'b1};

  // positions inside the synchronized command vector
  localparam int unsigned IDX_FLT = 0;
  localparam int unsigned IDX_UV  = 1;
  localparam int unsigned IDX_EN  = 2;
  localparam int unsigned IDX_DIS = 3;
  localparam int unsigned IDX_POL = 4;

  function automatic leg_drv_t leg_decode(input logic off, input logic pol);
    leg_drv_t r;
    if (off) begin
      r = LEG_OFF;
    end else begin
      r.hs  = pol;
      r.ls  = ~pol;
      r.hiz = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned      W       = 1,
  parameter int unsigned      STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg <= {stg[STAGES-2:0], d_i};
    end
  end

  assign q_o = stg[LAST];

  initial begin
    if (STAGES < 2) $display("hb_sync: STAGES must be at least 2");
  end

endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch (
  input  logic clk,
  input  logic rst,
  input  logic dis_s,
  input  logic en_s,
  input  logic flt_s,
  output logic lat_nxt_o,
  output logic lat_q_o
);

  logic dis_prev, en_prev, lat_q, clr_evt, lat_nxt;

  // clear on disable falling or enable rising, both on synchronized values
  assign clr_evt = (dis_prev & ~dis_s) | (~en_prev & en_s);
  // a new request wins over a simultaneous clear
  assign lat_nxt = flt_s | (lat_q & ~clr_evt);

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_prev <= 1'b1;
      en_prev  <= 1'b0;
      lat_q    <= 1'b0;
    end else begin
      dis_prev <= dis_s;
      en_prev  <= en_s;
      lat_q    <= lat_nxt;
    end
  end

  assign lat_nxt_o = lat_nxt;
  assign lat_q_o   = lat_q;

  // R8: a request always ends up latched, even against a clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    flt_s |=> lat_q);

  // R8: the latch falls only after a clear event
  p_clear_source_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(lat_q) |-> $past(clr_evt));

endmodule

// File: rtl/hb_leg_drv.sv
module hb_leg_drv
  import hb_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic off_i,
  input  logic pol_i,
  output logic hs_o,
  output logic ls_o,
  output logic hiz_o
);

  leg_drv_t drv_nxt, drv_q;

  always_comb drv_nxt = leg_decode(off_i, pol_i);

  always_ff @(posedge clk) begin
    if (rst) drv_q <= LEG_OFF;
    else     drv_q <= drv_nxt;
  end

  assign hs_o  = drv_q.hs;
  assign ls_o  = drv_q.ls;
  assign hiz_o = drv_q.hiz;

  // R4: exactly one drive state per leg, never both switches
  p_one_state_r4: assert property (@(posedge clk) disable iff (rst)
    $countones({hs_o, ls_o, hiz_o}) == 1);

  p_no_shoot_r4: assert property (@(posedge clk) disable iff (rst)
    !(hs_o && ls_o));

endmodule

// File: rtl/hb_cmd_top.sv
module hb_cmd_top
  import hb_cmd_pkg::*;
#(
  parameter int unsigned LEGS        = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LEGS-1:0] pol_i,
  input  logic            dis_i,
  input  logic            en_i,
  input  logic            uv_i,
  input  logic            flt_i,
  output logic [LEGS-1:0] hs_on_o,
  output logic [LEGS-1:0] ls_on_o,
  output logic [LEGS-1:0] hiz_o,
  output logic            stat_n_o,
  output logic            sleep_o
);

  localparam int unsigned VW = LEGS + IDX_POL;
  // idle values modelling the input pulls
  localparam logic [VW-1:0] SYNC_RST = {{LEGS{1'b1}}, 1'b1, 1'b0, 1'b0, 1'b0};

  logic [VW-1:0]   raw_vec, syn_vec;
  logic [LEGS-1:0] pol_s;
  logic            dis_s, en_s, uv_s, flt_s;
  logic            lat_nxt, lat_q, bridge_off;
  logic            stat_n_q, sleep_q;

  assign raw_vec = {pol_i, dis_i, en_i, uv_i, flt_i};

  hb_sync #(
    .W      (VW),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_vec),
    .q_o (syn_vec)
  );

  assign flt_s = syn_vec[IDX_FLT];
  assign uv_s  = syn_vec[IDX_UV];
  assign en_s  = syn_vec[IDX_EN];
  assign dis_s = syn_vec[IDX_DIS];
  assign pol_s = syn_vec[IDX_POL +: LEGS];

  hb_fault_latch u_flt (
    .clk      (clk),
    .rst      (rst),
    .dis_s    (dis_s),
    .en_s     (en_s),
    .flt_s    (flt_s),
    .lat_nxt_o(lat_nxt),
    .lat_q_o  (lat_q)
  );

  // decoded from the next latch value so a clear releases on the same edge
  assign bridge_off = ~en_s | dis_s | uv_s | lat_nxt;

  generate
    for (genvar k = 0; k < LEGS; k++) begin : g_leg
      hb_leg_drv u_leg (
        .clk  (clk),
        .rst  (rst),
        .off_i(bridge_off),
        .pol_i(pol_s[k]),
        .hs_o (hs_on_o[k]),
        .ls_o (ls_on_o[k]),
        .hiz_o(hiz_o[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_n_q <= 1'b1;
      sleep_q  <= 1'b1;
    end else begin
      stat_n_q <= ~(en_s & (dis_s | uv_s | lat_nxt));
      sleep_q  <= ~en_s;
    end
  end

  assign stat_n_o = stat_n_q;
  assign sleep_o  = sleep_q;

  // R6: sleep keeps legs off and the flag released
  p_sleep_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    sleep_o |-> (&hiz_o && stat_n_o));

  // R7: a held fault keeps the bridge off and the flag set
  p_fault_off_r7: assert property (@(posedge clk) disable iff (rst)
    (lat_q && !sleep_o) |-> (&hiz_o && !stat_n_o));

  // R5: synchronized disable while enabled shows on the flag next edge
  p_dis_flag_r5: assert property (@(posedge clk) disable iff (rst)
    $past(dis_s && en_s) |-> (!stat_n_o && &hiz_o));

  // R9: undervoltage while enabled switches off and sets the flag
  p_uv_off_r9: assert property (@(posedge clk) disable iff (rst)
    $past(uv_s && en_s) |-> (!stat_n_o && &hiz_o));

endmodule

// File: tb/hb_cmd_top_bench.sv
module hb_cmd_top_bench;

  localparam int LEGS = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst;
  logic [LEGS-1:0] pol;
  logic            dis, en, uv, flt;
  logic [LEGS-1:0] hs, ls, hiz;
  logic            stn, slp;

  hb_cmd_top #(.LEGS(LEGS), .SYNC_STAGES(2)) u_hb_cmd_top (
    .clk(clk), .rst(rst), .pol_i(pol), .dis_i(dis), .en_i(en),
    .uv_i(uv), .flt_i(flt), .hs_on_o(hs), .ls_on_o(ls), .hiz_o(hiz),
    .stat_n_o(stn), .sleep_o(slp)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  string phase  = "R1";
  bit    done   = 0;
  bit    m_live = 0;

  // behavioural reference: two-deep input history, edge memory, latch
  bit [LEGS-1:0] h_pol[2];
  bit            h_dis[2], h_en[2], h_uv[2], h_flt[2];
  bit            m_pdis, m_pen, m_lat;
  bit [LEGS-1:0] e_hs, e_ls, e_hiz;
  bit            e_stn, e_slp;

  always @(posedge clk) begin
    bit clr, nl, off;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        h_pol[i] = '1; h_dis[i] = 1; h_en[i] = 0; h_uv[i] = 0; h_flt[i] = 0;
      end
      m_pdis = 1; m_pen = 0; m_lat = 0;
      e_hs = '0; e_ls = '0; e_hiz = '1; e_stn = 1; e_slp = 1;
      m_live = 1;
    end else begin
      clr = (m_pdis && !h_dis[1]) || (!m_pen && h_en[1]);
      nl  = h_flt[1] ? 1'b1 : (clr ? 1'b0 : m_lat);
      off = !h_en[1] || h_dis[1] || h_uv[1] || nl;
      e_hs  = off ? '0 : h_pol[1];
      e_ls  = off ? '0 : ~h_pol[1];
      e_hiz = off ? '1 : '0;
      e_stn = !(h_en[1] && (h_dis[1] || h_uv[1] || nl));
      e_slp = !h_en[1];
      m_lat = nl; m_pdis = h_dis[1]; m_pen = h_en[1];
      h_pol[1] = h_pol[0]; h_dis[1] = h_dis[0]; h_en[1] = h_en[0];
      h_uv[1] = h_uv[0]; h_flt[1] = h_flt[0];
      h_pol[0] = pol; h_dis[0] = dis; h_en[0] = en; h_uv[0] = uv; h_flt[0] = flt;
    end
  end

  always @(negedge clk) begin
    if (m_live && !done) begin
      n_chk++;
      if ({hs, ls, hiz, stn, slp} !== {e_hs, e_ls, e_hiz, e_stn, e_slp}) begin
        n_fail++;
        $display("FAIL %s model: hs=%b ls=%b hiz=%b stn=%b slp=%b expected hs=%b ls=%b hiz=%b stn=%b slp=%b",
                 phase, hs, ls, hiz, stn, slp, e_hs, e_ls, e_hiz, e_stn, e_slp);
      end
      n_chk++;
      if (|(hs & ls) || (hs | ls | hiz) !== '1) begin
        n_fail++;
        $display("FAIL R4 leg state: hs=%b ls=%b hiz=%b expected one-hot per leg", hs, ls, hiz);
      end
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_io(input string tag, input bit [LEGS-1:0] x_hs,
                           input bit [LEGS-1:0] x_ls, input bit [LEGS-1:0] x_hiz,
                           input bit x_stn, input bit x_slp);
    n_chk++;
    if ({hs, ls, hiz, stn, slp} !== {x_hs, x_ls, x_hiz, x_stn, x_slp}) begin
      n_fail++;
      $display("FAIL %s: hs=%b ls=%b hiz=%b stn=%b slp=%b expected hs=%b ls=%b hiz=%b stn=%b slp=%b",
               tag, hs, ls, hiz, stn, slp, x_hs, x_ls, x_hiz, x_stn, x_slp);
    end
  endtask

  task automatic fault_pulse();
    flt = 1; settle(1); flt = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst = 1; pol = '1; dis = 1; en = 0; uv = 0; flt = 0;
    settle(3);
    expect_io("R1 in reset", 2'b00, 2'b00, 2'b11, 1, 1);
    rst = 0;
    settle(1);
    expect_io("R1 after reset", 2'b00, 2'b00, 2'b11, 1, 1);

    phase = "R2";
    pol = 2'b01; dis = 0; en = 1; settle(4);
    expect_io("R2 leg0 high leg1 low", 2'b01, 2'b10, 2'b00, 1, 0);
    pol = 2'b10; settle(4);
    expect_io("R2 reverse", 2'b10, 2'b01, 2'b00, 1, 0);

    phase = "R3";
    pol = 2'b00; settle(4);
    expect_io("R3 low freewheel", 2'b00, 2'b11, 2'b00, 1, 0);
    pol = 2'b11; settle(4);
    expect_io("R3 high freewheel", 2'b11, 2'b00, 2'b00, 1, 0);

    phase = "R10";
    pol = 2'b00; settle(2);
    expect_io("R10 two edges later unchanged", 2'b11, 2'b00, 2'b00, 1, 0);
    settle(1);
    expect_io("R10 third edge applies", 2'b00, 2'b11, 2'b00, 1, 0);

    phase = "R5";
    dis = 1; settle(4);
    expect_io("R5 disable", 2'b00, 2'b00, 2'b11, 0, 0);
    dis = 0; settle(4);
    expect_io("R5 re-enabled", 2'b00, 2'b11, 2'b00, 1, 0);

    phase = "R6";
    en = 0; dis = 1; uv = 1; settle(4);
    expect_io("R6 sleep masks flag", 2'b00, 2'b00, 2'b11, 1, 1);
    uv = 0; dis = 0; en = 1; settle(4);
    expect_io("R6 wake", 2'b00, 2'b11, 2'b00, 1, 0);

    phase = "R7";
    pol = 2'b01; fault_pulse(); settle(4);
    expect_io("R7 fault latched", 2'b00, 2'b00, 2'b11, 0, 0);
    pol = 2'b10; settle(4);
    expect_io("R7 polarity ignored", 2'b00, 2'b00, 2'b11, 0, 0);

    phase = "R8";
    dis = 1; settle(4);
    expect_io("R8 disable rise keeps fault", 2'b00, 2'b00, 2'b11, 0, 0);
    phase = "R11";
    dis = 0; settle(2);
    expect_io("R11 before clear edge", 2'b00, 2'b00, 2'b11, 0, 0);
    settle(1);
    expect_io("R11 resumes on clear edge", 2'b10, 2'b01, 2'b00, 1, 0);

    phase = "R8";
    fault_pulse(); settle(4);
    uv = 1; settle(4); uv = 0; settle(4);
    expect_io("R8 undervoltage does not clear", 2'b00, 2'b00, 2'b11, 0, 0);
    en = 0; settle(4);
    expect_io("R8 sleep while latched", 2'b00, 2'b00, 2'b11, 1, 1);
    en = 1; settle(3);
    expect_io("R8 enable rise clears", 2'b10, 2'b01, 2'b00, 1, 0);

    fault_pulse(); settle(3);
    dis = 1; settle(4);
    dis = 0; flt = 1; settle(1); flt = 0; settle(4);
    expect_io("R8 fault beats same-cycle clear", 2'b00, 2'b00, 2'b11, 0, 0);
    dis = 1; settle(3); dis = 0; settle(4);
    expect_io("R8 later clear works", 2'b10, 2'b01, 2'b00, 1, 0);

    phase = "R9";
    uv = 1; settle(4);
    expect_io("R9 undervoltage off", 2'b00, 2'b00, 2'b11, 0, 0);
    uv = 0; settle(4);
    expect_io("R9 self release", 2'b10, 2'b01, 2'b00, 1, 0);

    settle(2);
    finish_run();
  end

endmodule